// File: doc/BRIEF.md
# Dual-Channel Aligned PWM Timer

This timer counts a clock-enable strobe and drives two pulse-width modulated pins, A and B. Both pins share one period. A 3-bit period code selects that period in steps of 128 counts. Each channel compares the count against its own duty value, so the two pins carry different duty cycles at the same frequency.

Two alignments are available. In edge alignment the counter runs upward and every pulse starts when the count returns to zero. In centre alignment the counter runs up and then back down, which doubles the cycle length. Each pulse then sits symmetrically around the bottom of the count, so pulses of different widths share a common centre instead of a common leading edge.

Each pin has a polarity bit and a two-bit output mode, which selects between passing the waveform and forcing the pin to a fixed level. Three sticky flags report the end of each cycle and a compare match on each channel. All configuration arrives on plain level inputs. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_dual_timer`

## Requirements
- R1: In edge alignment the cycle lasts P counts. P is 128 times `period_code`, and code 0 gives 1024.
- R2: In edge alignment a channel with duty D (0 < D < P) is active for D consecutive counts from the start of each cycle, so both channels' pulses begin on the same clock.
- R3: With `centre_align` = 1 the cycle lasts 2P counts. A channel is active for 2D counts, centred on the bottom of the count, so a narrower pulse starts (D_wide − D_narrow) counts after a wider one and ends the same number of counts before it.
- R4: A duty value equal to or greater than P keeps the channel active for the whole cycle.
- R5: A duty value of 0 keeps the channel inactive for the whole cycle.
- R6: The active level is high when the polarity bit is 0. The polarity bit set to 1 inverts the pin.
- R7: The output mode encodings are: 2'b00 and 2'b11 pass the waveform, 2'b01 forces the pin low, and 2'b10 forces the pin high. A forced level also applies while the timer is stopped.
- R8: Three sticky flags are provided.
  - `flag_period` sets at the end of every cycle.
  - `flag_a` and `flag_b` set when the rising count equals that channel's duty value while that value is below P. A duty of P or more never sets its flag.
  - A flag stays set until a 1 is written to its bit of `flag_clear` (bit 0 = period, bit 1 = A, bit 2 = B). A set on the same clock wins over the clear.
- R9: The counter advances only on clocks with `tick_en` = 1. While `run` = 0 the count is held at zero and each passing-mode pin sits at its inactive level, which equals its polarity bit. Out of reset the pins are low and the flags are clear.
- R10: While running, the period code, the alignment and the duty values are sampled only at the end of a cycle. A change made during a pulse does not alter that pulse. While stopped they are taken directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Timer enable; 0 holds the count at zero |
| tick_en | input | 1 | Count strobe; the counter moves one step per clock with this high |
| period_code | input | 3 | Period select, P = 128 × code, code 0 gives 1024 |
| centre_align | input | 1 | 0 = edge alignment, 1 = centre alignment |
| duty_a | input | 11 | Compare value of channel A |
| duty_b | input | 11 | Compare value of channel B |
| polarity_a | input | 1 | 1 inverts pin A |
| polarity_b | input | 1 | 1 inverts pin B |
| mode_a | input | 2 | Output mode of pin A |
| mode_b | input | 2 | Output mode of pin B |
| flag_clear | input | 3 | Write-one-to-clear strobes for the period, A and B flags |
| pwm_a | output | 1 | Pin A |
| pwm_b | output | 1 | Pin B |
| flag_period | output | 1 | Sticky end-of-cycle flag |
| flag_a | output | 1 | Sticky compare-match flag of channel A |
| flag_b | output | 1 | Sticky compare-match flag of channel B |

## Verification
Nearly every internal fault shows up as a wrong spacing or a wrong width of pulses on the pins within one or two cycles.
- A counter that wraps early or misses the turn at the top changes the spacing between rising edges at once.
- A wrong comparison on the falling half of a centre cycle shifts one channel's edges against the other's by a count or two.
- Shadow registers that load at the wrong moment appear in the very next pulse, as a width that follows a mid-pulse write instead of ignoring it.

Flag faults take longer to see. They appear only after a full cycle has run and the timer is stopped and its flags read.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Output mode field of each channel
  typedef enum logic [1:0] {
    OM_PASS     = 2'b00,
    OM_LOW      = 2'b01,
    OM_HIGH     = 2'b10,
    OM_PASS_ALT = 2'b11
  } out_mode_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow #(
  parameter int UNIT   = 128,
  parameter int CODE_W = 3,
  parameter int CNT_W  = 11,
  parameter int NCH    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [CODE_W-1:0]             code_in,
  input  logic                          centre_in,
  input  logic [NCH-1:0][CNT_W-1:0]     duty_in,
  output logic [CNT_W-1:0]              per_q,
  output logic                          centre_q,
  output logic [NCH-1:0][CNT_W-1:0]     duty_q
);

  logic [CNT_W-1:0] per_n;

  // Period value decoded from the code; the all-zero code selects the largest period
  always_comb begin
    if (code_in == '0) per_n = CNT_W'(UNIT) << CODE_W;
    else               per_n = CNT_W'(code_in) * CNT_W'(UNIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q    <= CNT_W'(UNIT);
      centre_q <= 1'b0;
    end else if (load) begin
      per_q    <= per_n;
      centre_q <= centre_in;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_duty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    duty_q[c] <= '0;
      else if (load) duty_q[c] <= duty_in[c];
    end
  end

  // R10: settings stay frozen between cycle boundaries
  a_r10_period_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(per_q) && $stable(centre_q)));
  a_r10_duty_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_q));

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             centre,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             down,
  output logic             cyc_end
);

  logic at_top;
  logic at_floor;

  assign at_top   = (cnt == per - CNT_W'(1));
  assign at_floor = (cnt == CNT_W'(1));
  assign cyc_end  = run && tick && (centre ? (down && at_floor) : at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      if (!centre) begin
        down <= 1'b0;
        cnt  <= at_top ? '0 : cnt + CNT_W'(1);
      end else if (!down) begin
        // rising half: 0 .. P-1, then turn at P
        if (at_top) down <= 1'b1;
        cnt <= cnt + CNT_W'(1);
      end else begin
        // falling half: P .. 1, then back to 0
        if (at_floor) down <= 1'b0;
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R9: stopped timer sits at zero
  a_r9_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !down));
  // R9: no movement without a tick
  a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));
  // R1, R3: count never leaves its range
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    down ? (cnt <= per) : (cnt < per));

endmodule

// File: rtl/pwm_out_channel.sv
module pwm_out_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             down,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] duty,
  input  logic             pol,
  input  logic [1:0]       mode,
  input  logic             clr,
  output logic             pin,
  output logic             flag
);

  out_mode_e mode_e;
  logic      active;
  logic      match;

  assign mode_e = out_mode_e'(mode);

  // Rising half uses <, falling half uses <= so the pulse spans exactly 2D in centre mode
  assign active = run && (down ? (cnt <= duty) : (cnt < duty));
  assign match  = run && tick && !down && (cnt == duty) && (duty < per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else begin
      unique case (mode_e)
        OM_LOW:  pin <= 1'b0;
        OM_HIGH: pin <= 1'b1;
        default: pin <= active ^ pol;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= match | (flag & ~clr);
  end

  // R7: forced levels reach the pin on the next clock
  a_r7_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> !pin);
  a_r7_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> pin);
  // R5: zero duty never activates a passing, non-inverted pin
  a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0 && !pol && mode == 2'b00) |=> !pin);
  // R8: flag holds until cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer #(
  parameter  int UNIT   = 128,
  parameter  int CODE_W = 3,
  localparam int CNT_W  = $clog2(UNIT << CODE_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] period_code,
  input  logic              centre_align,
  input  logic [CNT_W-1:0]  duty_a,
  input  logic [CNT_W-1:0]  duty_b,
  input  logic              polarity_a,
  input  logic              polarity_b,
  input  logic [1:0]        mode_a,
  input  logic [1:0]        mode_b,
  input  logic [2:0]        flag_clear,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              flag_period,
  output logic              flag_a,
  output logic              flag_b
);

  import pwm_timer_pkg::*;

  logic [NUM_CH-1:0][CNT_W-1:0] duty_in;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_sh;
  logic [NUM_CH-1:0]            pol_v;
  logic [NUM_CH-1:0][1:0]       mode_v;
  logic [NUM_CH-1:0]            clr_v;
  logic [NUM_CH-1:0]            pin_v;
  logic [NUM_CH-1:0]            flag_v;
  logic [CNT_W-1:0]             per_sh;
  logic                         centre_sh;
  logic [CNT_W-1:0]             cnt;
  logic                         down;
  logic                         cyc_end;
  logic                         load;

  assign duty_in = {duty_b, duty_a};
  assign pol_v   = {polarity_b, polarity_a};
  assign mode_v  = {mode_b, mode_a};
  assign clr_v   = flag_clear[2:1];
  assign load    = !run || cyc_end;

  pwm_cfg_shadow #(
    .UNIT(UNIT), .CODE_W(CODE_W), .CNT_W(CNT_W), .NCH(NUM_CH)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .code_in(period_code), .centre_in(centre_align), .duty_in(duty_in),
    .per_q(per_sh), .centre_q(centre_sh), .duty_q(duty_sh)
  );

  pwm_updown_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en),
    .centre(centre_sh), .per(per_sh),
    .cnt(cnt), .down(down), .cyc_end(cyc_end)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_out_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en),
      .cnt(cnt), .down(down), .per(per_sh), .duty(duty_sh[c]),
      .pol(pol_v[c]), .mode(mode_v[c]), .clr(clr_v[c]),
      .pin(pin_v[c]), .flag(flag_v[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_period <= 1'b0;
    else        flag_period <= cyc_end | (flag_period & ~flag_clear[0]);
  end

  assign pwm_a  = pin_v[0];
  assign pwm_b  = pin_v[1];
  assign flag_a = flag_v[0];
  assign flag_b = flag_v[1];

  // R8: an end of cycle always leaves the period flag set
  a_r8_period_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> flag_period);
  // R8: a clear with no new end of cycle drops the period flag
  a_r8_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clear[0] && !cyc_end) |=> !flag_period);

endmodule

// File: tb/test_pwm_dual_timer.sv
`timescale 1ns/1ps
module test_pwm_dual_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        tick_en = 1'b1;
  logic        tick_half = 1'b0;
  logic [2:0]  period_code = 3'd1;
  logic        centre_align = 1'b0;
  logic [10:0] duty_a = '0;
  logic [10:0] duty_b = '0;
  logic        polarity_a = 1'b0;
  logic        polarity_b = 1'b0;
  logic [1:0]  mode_a = 2'b00;
  logic [1:0]  mode_b = 2'b00;
  logic [2:0]  flag_clear = '0;
  logic        pwm_a, pwm_b, flag_period, flag_a, flag_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pwm_dual_timer i_pwm_dual_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
    .period_code(period_code), .centre_align(centre_align),
    .duty_a(duty_a), .duty_b(duty_b),
    .polarity_a(polarity_a), .polarity_b(polarity_b),
    .mode_a(mode_a), .mode_b(mode_b), .flag_clear(flag_clear),
    .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flag_period(flag_period), .flag_a(flag_a), .flag_b(flag_b)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) tick_en <= tick_half ? ~tick_en : 1'b1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic pin(input int sel);
    return sel == 0 ? pwm_a : pwm_b;
  endfunction

  task automatic wait_edge(input int sel, input bit rising, output int t);
    logic pv = pin(sel);
    t = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pin(sel) == rising && pv == !rising) begin
        t = cyc;
        return;
      end
      pv = pin(sel);
    end
    check(0, "edge timeout", 0, 1);
  endtask

  task automatic setup(input int code, input bit ctr, input int da, input int db,
                       input bit pa, input bit pb, input int settle);
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    period_code = 3'(code); centre_align = ctr;
    duty_a = 11'(da); duty_b = 11'(db);
    polarity_a = pa; polarity_b = pb;
    @(negedge clk);
    run = 1'b1;
    repeat (settle) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int ca, output int cb);
    ca = 0; cb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int'(pwm_a);
      cb += int'(pwm_b);
    end
  endtask

  task automatic spacing(input int sel, input int exp, input string tag);
    int t1, t2;
    wait_edge(sel, 1'b1, t1);
    wait_edge(sel, 1'b1, t2);
    check(t2 - t1 == exp, tag, t2 - t1, exp);
  endtask

  task automatic t_reset;
    check(pwm_a == 0 && pwm_b == 0, "R9 reset pins low", int'({pwm_a, pwm_b}), 0);
    check({flag_period, flag_a, flag_b} == 0, "R9 reset flags clear",
          int'({flag_period, flag_a, flag_b}), 0);
  endtask

  task automatic t_edge_basic;
    int ca, cb, miss;
    logic pa, pb;
    setup(1, 0, 40, 100, 0, 0, 300);
    spacing(0, 128, "R1 edge period code 1");
    count_high(256, ca, cb);
    check(ca == 80, "R2 duty A 40 over two cycles", ca, 80);
    check(cb == 200, "R2 duty B 100 over two cycles", cb, 200);
    miss = 0; pa = pwm_a; pb = pwm_b;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if ((pwm_a && !pa) != (pwm_b && !pb)) miss++;
      pa = pwm_a; pb = pwm_b;
    end
    check(miss == 0, "R2 leading edges coincide", miss, 0);
  endtask

  task automatic t_codes;
    setup(3, 0, 40, 40, 0, 0, 500);
    spacing(0, 384, "R1 edge period code 3");
    setup(7, 0, 40, 40, 0, 0, 1000);
    spacing(0, 896, "R1 edge period code 7");
    setup(0, 0, 40, 40, 0, 0, 1100);
    spacing(0, 1024, "R1 edge period code 0");
  endtask

  task automatic t_centre;
    int ca, cb, ra, rb, fa, fb;
    setup(1, 1, 40, 20, 0, 0, 300);
    spacing(0, 256, "R3 centre cycle length");
    count_high(512, ca, cb);
    check(ca == 160, "R3 centre width A", ca, 160);
    check(cb == 80, "R3 centre width B", cb, 80);
    wait_edge(0, 1'b1, ra);
    wait_edge(1, 1'b1, rb);
    wait_edge(1, 1'b0, fb);
    wait_edge(0, 1'b0, fa);
    check(rb - ra == 20, "R3 narrow pulse starts later", rb - ra, 20);
    check(fa - fb == 20, "R3 narrow pulse ends earlier", fa - fb, 20);
  endtask

  task automatic t_full_zero;
    int ca, cb;
    setup(1, 0, 128, 200, 0, 0, 300);
    count_high(256, ca, cb);
    check(ca == 256, "R4 duty equal to period", ca, 256);
    check(cb == 256, "R4 duty above period", cb, 256);
    setup(1, 1, 300, 0, 0, 0, 300);
    count_high(512, ca, cb);
    check(ca == 512, "R4 centre full duty", ca, 512);
    check(cb == 0, "R5 zero duty inactive", cb, 0);
  endtask

  task automatic t_polarity;
    int ca, cb;
    setup(1, 0, 40, 40, 1, 0, 300);
    count_high(256, ca, cb);
    check(ca == 176, "R6 inverted duty A", ca, 176);
    check(cb == 80, "R6 normal duty B", cb, 80);
    run = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm_a == 1, "R9 stopped inactive level inverted", int'(pwm_a), 1);
    check(pwm_b == 0, "R9 stopped inactive level normal", int'(pwm_b), 0);
    polarity_a = 1'b0;
  endtask

  task automatic t_modes;
    int ca, cb;
    setup(1, 0, 200, 0, 0, 0, 300);
    mode_a = 2'b01; mode_b = 2'b10;
    repeat (2) @(negedge clk);
    count_high(256, ca, cb);
    check(ca == 0, "R7 force low", ca, 0);
    check(cb == 256, "R7 force high", cb, 256);
    run = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm_b == 1, "R7 force high while stopped", int'(pwm_b), 1);
    mode_a = 2'b11; mode_b = 2'b00;
    setup(1, 0, 40, 40, 0, 0, 300);
    count_high(256, ca, cb);
    check(ca == 80, "R7 mode 11 passes waveform", ca, 80);
  endtask

  task automatic t_tick;
    setup(1, 0, 40, 40, 0, 0, 10);
    tick_half = 1'b1;
    repeat (600) @(negedge clk);
    spacing(0, 256, "R9 half-rate tick doubles period");
    tick_half = 1'b0;
  endtask

  task automatic t_flags;
    @(negedge clk);
    run = 1'b0;
    flag_clear = 3'b111;
    @(negedge clk);
    flag_clear = 3'b000;
    check({flag_period, flag_a, flag_b} == 0, "R8 clear strobe",
          int'({flag_period, flag_a, flag_b}), 0);
    setup(1, 0, 40, 200, 0, 0, 300);
    run = 1'b0;
    repeat (2) @(negedge clk);
    check(flag_period == 1, "R8 period flag set", int'(flag_period), 1);
    check(flag_a == 1, "R8 flag A set", int'(flag_a), 1);
    check(flag_b == 0, "R8 duty above period gives no flag B", int'(flag_b), 0);
    repeat (20) @(negedge clk);
    check(flag_period && flag_a, "R8 flags sticky", int'({flag_period, flag_a}), 3);
    flag_clear = 3'b011;
    @(negedge clk);
    flag_clear = 3'b000;
    check(!flag_period && !flag_a, "R8 flags cleared", int'({flag_period, flag_a}), 0);
  endtask

  task automatic t_shadow;
    int t, w;
    setup(1, 0, 40, 40, 0, 0, 300);
    wait_edge(0, 1'b1, t);
    w = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (w == 10) duty_a = 11'd100;
      if (pwm_a) w++;
      else break;
    end
    check(w == 40, "R10 pulse in flight keeps old duty", w, 40);
    wait_edge(0, 1'b1, t);
    w = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_a) w++;
      else break;
    end
    check(w == 100, "R10 new duty at next cycle", w, 100);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_edge_basic();
    t_codes();
    t_centre();
    t_full_zero();
    t_polarity();
    t_modes();
    t_tick();
    t_flags();
    t_shadow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule